// File: doc/BRIEF.md
# Comb Decimator with Passband Droop Correction

This block takes one complex baseband channel at the high sample rate and lowers its rate by a fixed factor of five. The in-phase and quadrature rails travel through identical, independent lanes. Each lane runs a cascade of four wrapping integrators at the input rate. It then runs four differencing stages at the decimated rate, which together form the comb response ((1 - z^-5) / (1 - z^-1))^4.

The comb's magnitude falls off across the passband. A three-tap symmetric correction filter, running only at the decimated rate, restores it. Its outer taps are -ε and its centre tap is 1 + 2ε, so the filter's DC gain is exactly one. ε is held in an internal register that loads from a port. After reset it takes a value derived from the comb order and the decimation factor.

Outputs are kept at full precision. A constant input therefore appears scaled by 5^4 · 2^16, and dividing by that factor gives unity gain. The results of the first three decimated samples after reset are suppressed while the filter history fills.

Top module: `cic_droop_decim`

## Requirements
- R1: While `rstN` is low, `outValid` is 0 and `outI` and `outQ` are 0.
- R2: Input samples accepted (with `inValid` high) are numbered from 0 after reset. A decimated sample is taken at the edge that accepts sample 5m+4. Its result appears on the outputs with a one-cycle `outValid` pulse after the next rising edge, whatever `inValid` does in between.
- R3: The results of decimated samples m = 0, 1 and 2 produce no `outValid` pulse. The first pulse carries m = 3, following the edge after the one that accepts input sample 19.
- R4: A cycle with `inValid` low accepts nothing. The data inputs in such a cycle have no effect on any later output.
- R5: Decimated sample m of the comb section, c[m], is the fourth difference, over m, of the four-fold running sum of the input, taken at input index 5m+4. Zero history is assumed before reset release.
- R6: The output for decimated sample m equals c[m-1]·2^16 + ε·(2·c[m-1] - c[m] - c[m-2]), with c[-1] = c[-2] = 0. This is the tap set (-ε, 1+2ε, -ε), where ε is a signed value with 16 fractional bits.
- R7: A constant input x gives, once settled, outputs equal to x · 625 · 65536. This is unity gain after normalisation.
- R8: After reset ε is 10486, which is round(4·(1 - 1/25)/24 · 2^16).
- R9: With `coefLoad` high at a rising edge, `coefIn` becomes ε for all later outputs. `coefIn` has no effect while `coefLoad` is low.
- R10: The I and Q lanes run the same filter and do not affect each other.
- R11: The integrators wrap at 24 bits. Results stay exact on runs long enough, and loud enough, to wrap them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input sample strobe |
| inI | input | 12 | In-phase input sample, two's complement |
| inQ | input | 12 | Quadrature input sample, two's complement |
| coefLoad | input | 1 | Load strobe for the correction coefficient |
| coefIn | input | 18 | New ε, signed, 16 fractional bits |
| outValid | output | 1 | Output strobe, one cycle per decimated result |
| outI | output | 45 | In-phase result, full precision, signed |
| outQ | output | 45 | Quadrature result, full precision, signed |

## Verification
The assertions rely on one property of this block's parameters: a decimation factor of at least two, which keeps any two decimation strobes apart. They also assume `inValid` and `coefLoad` are driven to known levels at every edge, because the hold properties on the integrators and on ε compare consecutive cycles. The bench drives every input at the falling edge so that each edge sees settled values. It keeps `coefLoad` to single-cycle pulses issued before a stream starts. It fills idle gaps with random data to exercise the cases where data must be ignored.

// File: rtl/cic_pkg.sv
package cic_pkg;
  // Strobes from the control unit to each datapath lane
  typedef struct packed {
    logic sampleEn; // accept one input sample into the integrators
    logic decimEn;  // take this sample into the comb section
    logic outEn;    // compute the corrected output from the comb history
  } cicStrobe_t;
endpackage

// File: rtl/cic_ctrl.sv
module cic_ctrl
  import cic_pkg::*;
#(
  parameter int DECIM     = 5,
  parameter int FILL      = 3,
  parameter int COEF_W    = 18,
  parameter int EPS_RESET = 10486
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic                     coefLoad,
  input  logic [COEF_W-1:0]        coefIn,
  output cicStrobe_t               strobe,
  output logic signed [COEF_W-1:0] epsVal,
  output logic                     outValid
);
  localparam int PH_W   = (DECIM > 1) ? $clog2(DECIM) : 1;
  localparam int FILL_W = $clog2(FILL + 2);

  logic [PH_W-1:0]   phase;
  logic              outEnQ;
  logic [FILL_W-1:0] fillCnt;
  logic              filled;
  logic              lastPhase;

  assign lastPhase = (phase == PH_W'(DECIM - 1));
  assign filled    = (fillCnt == FILL_W'(FILL));

  always_comb begin
    strobe.sampleEn = inValid;
    strobe.decimEn  = inValid && lastPhase;
    strobe.outEn    = outEnQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= '0;
      outEnQ   <= 1'b0;
      fillCnt  <= '0;
      outValid <= 1'b0;
      epsVal   <= COEF_W'(EPS_RESET);
    end else begin
      if (inValid) phase <= lastPhase ? '0 : phase + PH_W'(1);
      outEnQ   <= strobe.decimEn;
      outValid <= outEnQ && filled;
      if (outEnQ && !filled) fillCnt <= fillCnt + FILL_W'(1);
      if (coefLoad) epsVal <= coefIn;
    end
  end

  // R2: every output pulse traces back to a sample accepted two edges earlier
  p_out_follows_sample_r2: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid, 2));

  // R2: output strobe is a single-cycle pulse
  p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

  // R3: results computed while the history fills are not announced
  p_fill_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (outEnQ && !filled) |=> !outValid);

  // R9: coefficient only changes on a load strobe
  p_coef_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !coefLoad |=> $stable(epsVal));
endmodule

// File: rtl/cic_lane.sv
module cic_lane
  import cic_pkg::*;
#(
  parameter int IN_W   = 12,
  parameter int ORDER  = 4,
  parameter int ACC_W  = 24,
  parameter int COEF_W = 18,
  parameter int FRAC   = 16,
  parameter int OUT_W  = 45
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  cicStrobe_t               strobe,
  input  logic signed [COEF_W-1:0] epsVal,
  input  logic signed [IN_W-1:0]   din,
  output logic signed [OUT_W-1:0]  dout
);
  logic signed [ACC_W-1:0] integ    [ORDER];
  logic signed [ACC_W-1:0] integNxt [ORDER];
  logic signed [ACC_W-1:0] combIn   [ORDER];
  logic signed [ACC_W-1:0] dly      [ORDER];
  logic signed [ACC_W-1:0] combOut, dinExt;
  logic signed [ACC_W-1:0] cA, cB, cC;  // newest, centre, oldest comb result
  logic signed [OUT_W-1:0] wA, wB, wC, wE, diff, yNext;

  assign dinExt = {{(ACC_W-IN_W){din[IN_W-1]}}, din};

  // Integrator cascade, all stages settle on the same sample (wrapping adds)
  always_comb begin
    logic signed [ACC_W-1:0] acc;
    acc = dinExt;
    for (int k = 0; k < ORDER; k++) begin
      acc         = integ[k] + acc;
      integNxt[k] = acc;
    end
  end

  // Differencing stages at the decimated rate
  always_comb begin
    logic signed [ACC_W-1:0] t;
    t = integNxt[ORDER-1];
    for (int k = 0; k < ORDER; k++) begin
      combIn[k] = t;
      t         = t - dly[k];
    end
    combOut = t;
  end

  // Symmetric droop correction: taps -eps, 1+2eps, -eps
  always_comb begin
    wA    = {{(OUT_W-ACC_W){cA[ACC_W-1]}}, cA};
    wB    = {{(OUT_W-ACC_W){cB[ACC_W-1]}}, cB};
    wC    = {{(OUT_W-ACC_W){cC[ACC_W-1]}}, cC};
    wE    = {{(OUT_W-COEF_W){epsVal[COEF_W-1]}}, epsVal};
    diff  = (wB <<< 1) - wA - wC;
    yNext = (wB <<< FRAC) + diff * wE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < ORDER; k++) begin
        integ[k] <= '0;
        dly[k]   <= '0;
      end
      cA   <= '0;
      cB   <= '0;
      cC   <= '0;
      dout <= '0;
    end else begin
      if (strobe.sampleEn) begin
        for (int k = 0; k < ORDER; k++) integ[k] <= integNxt[k];
      end
      if (strobe.decimEn) begin
        for (int k = 0; k < ORDER; k++) dly[k] <= combIn[k];
        cA <= combOut;
        cB <= cA;
        cC <= cB;
      end
      if (strobe.outEn) dout <= yNext;
    end
  end

  // R4: idle cycles leave the integrator state untouched
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.sampleEn |=> $stable(integ[ORDER-1]));

  // R6: the result only moves when a corrected output is computed
  p_out_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.outEn |=> $stable(dout));
endmodule

// File: rtl/cic_droop_decim.sv
module cic_droop_decim
  import cic_pkg::*;
#(
  parameter  int IN_W   = 12,
  parameter  int DECIM  = 5,
  parameter  int ORDER  = 4,
  parameter  int COEF_W = 18,
  parameter  int FRAC   = 16,
  parameter  int FILL   = 3,
  localparam int ACC_W  = IN_W + ORDER * $clog2(DECIM),
  localparam int OUT_W  = ACC_W + COEF_W + 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [IN_W-1:0]   inI,
  input  logic [IN_W-1:0]   inQ,
  input  logic              coefLoad,
  input  logic [COEF_W-1:0] coefIn,
  output logic              outValid,
  output logic [OUT_W-1:0]  outI,
  output logic [OUT_W-1:0]  outQ
);
  // eps = round(ORDER * (1 - 1/DECIM^2) / 24 * 2^FRAC)
  localparam int D2        = DECIM * DECIM;
  localparam int EPS_RESET = (ORDER * (D2 - 1) * (1 << FRAC) + 12 * D2) / (24 * D2);
  localparam int LANES     = 2;

  cicStrobe_t               strobe;
  logic signed [COEF_W-1:0] epsVal;
  logic [IN_W-1:0]          laneIn  [LANES];
  logic [OUT_W-1:0]         laneOut [LANES];

  assign laneIn[0] = inI;
  assign laneIn[1] = inQ;
  assign outI      = laneOut[0];
  assign outQ      = laneOut[1];

  cic_ctrl #(
    .DECIM(DECIM), .FILL(FILL), .COEF_W(COEF_W), .EPS_RESET(EPS_RESET)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .coefLoad(coefLoad),
    .coefIn(coefIn), .strobe(strobe), .epsVal(epsVal), .outValid(outValid)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    cic_lane #(
      .IN_W(IN_W), .ORDER(ORDER), .ACC_W(ACC_W), .COEF_W(COEF_W),
      .FRAC(FRAC), .OUT_W(OUT_W)
    ) u_lane (
      .clk(clk), .rstN(rstN), .strobe(strobe), .epsVal(epsVal),
      .din(laneIn[g]), .dout(laneOut[g])
    );
  end
endmodule

// File: tb/cic_droop_decim_bench.sv
module cic_droop_decim_bench;
  localparam int IN_W   = 12;
  localparam int COEF_W = 18;
  localparam int OUT_W  = 45;
  localparam int MAXN   = 512;
  localparam int MAXD   = 128;
  localparam int FILL   = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                     rstN, inValid, coefLoad, outValid;
  logic signed [IN_W-1:0]   inI, inQ;
  logic [COEF_W-1:0]        coefIn;
  logic signed [OUT_W-1:0]  outI, outQ;

  cic_droop_decim u_cic_droop_decim (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inI(inI), .inQ(inQ),
    .coefLoad(coefLoad), .coefIn(coefIn), .outValid(outValid),
    .outI(outI), .outQ(outQ)
  );

  int nChk = 0;
  int nBad = 0;
  logic signed [IN_W-1:0] stI [MAXN];
  logic signed [IN_W-1:0] stQ [MAXN];
  longint eI [MAXD];
  longint eQ [MAXD];
  longint capI [MAXD];
  longint capQ [MAXD];
  int  nCap = 0;
  bit  capOn = 1'b0;
  longint epsDef = (4 * 24 * 65536 + 300) / 600;  // round(4*(24/25)/24 * 2^16)

  always @(negedge clk) begin
    if (capOn && outValid && nCap < MAXD) begin
      capI[nCap] = outI;
      capQ[nCap] = outQ;
      nCap++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; inValid = 1'b0; coefLoad = 1'b0; coefIn = '0; inI = '0; inQ = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  // Reference model built from the requirement equations
  task automatic calcModel(input int n, input longint eps);
    for (int r = 0; r < 2; r++) begin
      longint s [4];
      longint d [4];
      longint c [MAXD];
      int m;
      m = 0;
      for (int k = 0; k < 4; k++) begin s[k] = 0; d[k] = 0; end
      for (int i = 0; i < n; i++) begin
        longint x;
        x = (r == 0) ? longint'(stI[i]) : longint'(stQ[i]);
        s[0] += x; s[1] += s[0]; s[2] += s[1]; s[3] += s[2];
        if (i % 5 == 4) begin
          longint t;
          t = s[3];
          for (int k = 0; k < 4; k++) begin
            longint u;
            u = t - d[k]; d[k] = t; t = u;
          end
          c[m] = t;
          m++;
        end
      end
      for (int j = 0; j < m; j++) begin
        longint a, b, cc, y;
        a  = c[j];
        b  = (j >= 1) ? c[j-1] : 0;
        cc = (j >= 2) ? c[j-2] : 0;
        y  = b * 65536 + eps * (2 * b - a - cc);
        if (r == 0) eI[j] = y; else eQ[j] = y;
      end
    end
  endtask

  task automatic runStream(input int n, input int gap, input bit doLoad,
                           input int loadVal, input longint epsModel, input string req);
    int nd;
    doReset();
    nCap  = 0;
    capOn = 1'b1;
    if (doLoad) begin
      coefIn = COEF_W'(loadVal); coefLoad = 1'b1;
      @(negedge clk);
      coefLoad = 1'b0;
    end
    for (int i = 0; i < n; i++) begin
      inI = stI[i]; inQ = stQ[i]; inValid = 1'b1;
      coefIn = COEF_W'($urandom);
      @(negedge clk);
      if (gap > 0) begin
        inValid = 1'b0;
        inI = IN_W'($urandom); inQ = IN_W'($urandom);
        repeat (gap) @(negedge clk);
      end
    end
    inValid = 1'b0;
    repeat (6) @(negedge clk);
    capOn = 1'b0;
    calcModel(n, epsModel);
    nd = n / 5 - FILL;
    check(nCap == nd, req, "output count", nCap, nd);
    for (int k = 0; k < nCap && k < nd; k++) begin
      check(capI[k] == eI[k+FILL], req, $sformatf("I result %0d", k), capI[k], eI[k+FILL]);
      check(capQ[k] == eQ[k+FILL], req, $sformatf("Q result %0d", k), capQ[k], eQ[k+FILL]);
    end
  endtask

  task automatic testReset();
    rstN = 1'b0; inValid = 1'b0; coefLoad = 1'b0; coefIn = '0; inI = '0; inQ = '0;
    @(negedge clk);
    check(outValid == 1'b0, "R1", "outValid in reset", outValid, 0);
    check(outI == 0, "R1", "outI in reset", outI, 0);
    check(outQ == 0, "R1", "outQ in reset", outQ, 0);
  endtask

  task automatic testTiming();
    doReset();
    for (int i = 0; i < 45; i++) begin
      if (i > 0) begin
        bit expV;
        @(negedge clk);
        expV = (i >= 21) && ((i - 21) % 5 == 0);
        if (i < 21) check(outValid == expV, "R3", $sformatf("strobe before sample %0d", i), outValid, expV);
        else        check(outValid == expV, "R2", $sformatf("strobe before sample %0d", i), outValid, expV);
      end
      inI = 12'sd5; inQ = -12'sd5; inValid = 1'b1;
    end
    inValid = 1'b0;
    // R1: asynchronous reset clears outputs mid-run
    rstN = 1'b0;
    #1;
    check(outValid == 1'b0, "R1", "outValid after mid-run reset", outValid, 0);
    check(outI == 0, "R1", "outI after mid-run reset", outI, 0);
    @(negedge clk);
  endtask

  task automatic testImpulse();
    // R5 R6 R8 R10: I impulse, Q step, default coefficient
    for (int i = 0; i < MAXN; i++) begin
      stI[i] = (i == 0) ? 12'sd1000 : 12'sd0;
      stQ[i] = (i >= 10) ? -12'sd700 : 12'sd0;
    end
    runStream(80, 0, 1'b0, 0, epsDef, "R5/R6/R8/R10 impulse");
    check(eI[3] != 0 || eI[4] != 0, "R8", "impulse model non-trivial", eI[4], 1);
  endtask

  task automatic testDc();
    for (int i = 0; i < MAXN; i++) begin stI[i] = 12'sd1500; stQ[i] = -12'sd2048; end
    runStream(100, 0, 1'b0, 0, epsDef, "R7 dc");
    check(capI[nCap-1] == longint'(1500) * 625 * 65536, "R7", "settled I dc",
          capI[nCap-1], longint'(1500) * 625 * 65536);
    check(capQ[nCap-1] == longint'(-2048) * 625 * 65536, "R7", "settled Q dc",
          capQ[nCap-1], longint'(-2048) * 625 * 65536);
    check(capI[6] == longint'(1500) * 625 * 65536, "R7", "early settled I dc",
          capI[6], longint'(1500) * 625 * 65536);
  endtask

  task automatic testGaps();
    // R4: idle cycles carry random data that must be ignored
    for (int i = 0; i < MAXN; i++) begin
      stI[i] = IN_W'($urandom); stQ[i] = IN_W'($urandom);
    end
    runStream(150, 3, 1'b0, 0, epsDef, "R4 gaps");
  endtask

  task automatic testCoef();
    // R9: loaded coefficient used, coefIn churn without load ignored
    for (int i = 0; i < MAXN; i++) begin
      stI[i] = IN_W'($urandom); stQ[i] = (i % 9 < 4) ? 12'sd900 : -12'sd300;
    end
    runStream(120, 0, 1'b1, 30000, 30000, "R9 loaded coef");
    runStream(60, 1, 1'b1, -5000, -5000, "R9 negative coef");
  endtask

  task automatic testWrap();
    // R11: long full-scale run wraps the integrators
    for (int i = 0; i < MAXN; i++) begin
      stI[i] = (i % 7 < 4) ? 12'sd2047 : -12'sd2048;
      stQ[i] = 12'sd2047;
    end
    runStream(400, 0, 1'b0, 0, epsDef, "R11 wrap");
  endtask

  initial begin
    testReset();
    testTiming();
    testImpulse();
    testDc();
    testGaps();
    testCoef();
    testWrap();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChk++;
    nBad++;
    $display("FAIL watchdog: actual %0d cycles expected completion", 100000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule